// File: doc/BRIEF.md
# Mesh-Walk Microcode Sequencer

This block drives a small microcoded engine across a two-dimensional grid of points. On a start pulse it captures the column and row limits and the output base address, then visits every grid point in row-major order. For each point it writes the column and row numbers into the engine's first two general registers, restarts the program counter at zero and issues instructions one per cycle until the program reaches a vector-output instruction.

The vector-output instruction names two registers. The sequencer reads them through a register-file read port and posts a two-word memory write. The target address gives every row a fixed stride of 128 entries of 8 bytes each. The write is held on the port until the memory side acknowledges it. If a point's program runs past an instruction budget without producing output, that point is dropped and the sweep moves on. When the last point has been handled, the sequencer stores the number of grid points and raises a one-cycle interrupt. The arithmetic datapath that executes the other instructions lies outside this block and sees only the issue strobe and the fetched word.

Top module: `mesh_walk_seq`

## Requirements
- R1: Points are visited with the column index x as the inner loop and the row index y as the outer loop, both starting at 0 and running up to and including the captured limits.
- R2: Before a point runs, the block raises `coord_we_o` for one cycle with `coord_x_o` = x and `coord_y_o` = y. These are the values for registers 0 and 1.
- R3: For each point, the fetch address starts at 0. Each issued instruction pulses `issue_o` and advances the fetch address by one.
- R4: An instruction word has source A in bits 24:18, source B in bits 17:11, the opcode in bits 10:7 (value 7 means vector output) and the destination in bits 6:0. A vector output sends the register value named by source A as word 0 and the value named by source B as word 1.
- R5: The write address is base + 8*(128*y + x), and word 1 belongs at that address + 4. After the acknowledge, `last_dma_o` equals that address + 4.
- R6: While a write waits for `dma_ack_i`, the request, address and both data words stay unchanged and no instruction is issued.
- R7: A point that issues the instruction budget (parameter, 2048 by default) of non-output instructions ends without a memory write, and the sweep continues with the next point. A vector output fetched as the last instruction within the budget is still written.
- R8: At the end of a sweep, `irq_o` is high for exactly one cycle. From the next cycle on, `vertices_o` = (x limit + 1) * (y limit + 1).
- R9: `busy_o` goes high in the cycle after an accepted start and stays high through the interrupt cycle. A start pulse that arrives while busy, and any change to the limits during a sweep, have no effect.
- R10: After reset the block is idle: `busy_o`, `irq_o`, `dma_req_o`, `coord_we_o` and `issue_o` are low, and `vertices_o` and `last_dma_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| hlast_i | input | COORD_W | Last column index |
| vlast_i | input | COORD_W | Last row index |
| mesh_base_i | input | 32 | Byte base address of the output area |
| ucode_addr_o | output | PC_W | Microcode fetch address |
| ucode_data_i | input | 32 | Fetched instruction word, valid in the same cycle |
| issue_o | output | 1 | One non-output instruction is issued this cycle |
| rf_a_idx_o | output | 7 | Register index for source A |
| rf_b_idx_o | output | 7 | Register index for source B |
| rf_a_data_i | input | 32 | Value of register source A |
| rf_b_data_i | input | 32 | Value of register source B |
| coord_we_o | output | 1 | Write coordinates into registers 0 and 1 |
| coord_x_o | output | COORD_W | Current column index |
| coord_y_o | output | COORD_W | Current row index |
| dma_req_o | output | 1 | Two-word write request |
| dma_addr_o | output | 32 | Byte address of word 0 |
| dma_word0_o | output | 32 | Data for the address |
| dma_word1_o | output | 32 | Data for the address + 4 |
| dma_ack_i | input | 1 | Write accepted |
| last_dma_o | output | 32 | Address + 4 of the last completed write |
| vertices_o | output | 32 | Point count of the last finished sweep |
| irq_o | output | 1 | One-cycle end-of-sweep pulse |
| busy_o | output | 1 | Sweep in progress |

## Verification
Two things can land on the same fetch cycle: the instruction-budget check reaches its last allowed slot, and a vector output is decoded. A point whose output instruction sits exactly at the last budget position must still produce its write. A point with no output must end after exactly the budgeted number of issue pulses and produce no write. The bench builds both cases with a reduced budget and judges them by the count of issue pulses between coordinate loads, and by whether the write appears. It also places an abort on a middle point to confirm that the next point still follows in order.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_IDX_W = 7;
    localparam int OPC_W     = 4;

    localparam logic [OPC_W-1:0] OPC_VEC_OUT = 4'd7;

    // instruction word layout, msb first
    typedef struct packed {
        logic [6:0]           spare;
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] src_b;
        logic [OPC_W-1:0]     opcode;
        logic [REG_IDX_W-1:0] dest;
    } uinsn_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_RUN,
        SEQ_DMA,
        SEQ_DONE
    } seq_state_t;

    function automatic uinsn_t unpack_insn(input logic [WORD_W-1:0] w);
        return uinsn_t'(w);
    endfunction

    function automatic logic is_vec_out(input uinsn_t i);
        return i.opcode == OPC_VEC_OUT;
    endfunction

endpackage

// File: rtl/mesh_point_walker.sv
module mesh_point_walker #(
    parameter int COORD_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic               step,
    input  logic [COORD_W-1:0] hlast,
    input  logic [COORD_W-1:0] vlast,
    output logic [COORD_W-1:0] x,
    output logic [COORD_W-1:0] y,
    output logic               last
);
    always_ff @(posedge clk) begin
        if (rst || init) begin
            x <= '0;
            y <= '0;
        end else if (step) begin
            if (x == hlast) begin
                x <= '0;
                y <= y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

    assign last = (x == hlast) && (y == vlast);
endmodule

// File: rtl/mesh_insn_window.sv
module mesh_insn_window #(
    parameter int PC_W       = 11,
    parameter int INSN_LIMIT = 2048
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            advance,
    output logic [PC_W-1:0] pc,
    output logic            at_limit
);
    localparam int CNT_W = (INSN_LIMIT > 1) ? $clog2(INSN_LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(INSN_LIMIT - 1);

    logic [CNT_W-1:0] issued;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pc     <= '0;
            issued <= '0;
        end else if (advance) begin
            pc     <= pc + 1'b1;
            issued <= issued + 1'b1;
        end
    end

    // true while the instruction now being fetched is the last one allowed
    assign at_limit = (issued == CNT_TOP);
endmodule

// File: rtl/mesh_dma_stage.sv
module mesh_dma_stage #(
    parameter int COORD_W    = 7,
    parameter int ROW_STRIDE = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [31:0]        base,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [31:0]        word_a,
    input  logic [31:0]        word_b,
    input  logic               ack,
    output logic               req,
    output logic [31:0]        addr,
    output logic [31:0]        word0,
    output logic [31:0]        word1,
    output logic [31:0]        last_addr
);
    localparam int          ENTRY_SHIFT = 3;
    localparam logic [31:0] STRIDE      = 32'(ROW_STRIDE);

    logic [31:0] entry;
    assign entry = 32'(y) * STRIDE + 32'(x);

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            addr      <= '0;
            word0     <= '0;
            word1     <= '0;
            last_addr <= '0;
        end else if (load) begin
            req   <= 1'b1;
            addr  <= base + (entry << ENTRY_SHIFT);
            word0 <= word_a;
            word1 <= word_b;
        end else if (req && ack) begin
            req       <= 1'b0;
            last_addr <= addr + 32'd4;
        end
    end
endmodule

// File: rtl/mesh_walk_seq.sv
module mesh_walk_seq
    import mesh_seq_pkg::*;
#(
    parameter int COORD_W    = 7,
    parameter int ROW_STRIDE = 128,
    parameter int PC_W       = 11,
    parameter int INSN_LIMIT = 2048
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [COORD_W-1:0]   hlast_i,
    input  logic [COORD_W-1:0]   vlast_i,
    input  logic [31:0]          mesh_base_i,
    output logic [PC_W-1:0]      ucode_addr_o,
    input  logic [31:0]          ucode_data_i,
    output logic                 issue_o,
    output logic [REG_IDX_W-1:0] rf_a_idx_o,
    output logic [REG_IDX_W-1:0] rf_b_idx_o,
    input  logic [31:0]          rf_a_data_i,
    input  logic [31:0]          rf_b_data_i,
    output logic                 coord_we_o,
    output logic [COORD_W-1:0]   coord_x_o,
    output logic [COORD_W-1:0]   coord_y_o,
    output logic                 dma_req_o,
    output logic [31:0]          dma_addr_o,
    output logic [31:0]          dma_word0_o,
    output logic [31:0]          dma_word1_o,
    input  logic                 dma_ack_i,
    output logic [31:0]          last_dma_o,
    output logic [31:0]          vertices_o,
    output logic                 irq_o,
    output logic                 busy_o
);
    localparam int SPAN_W = COORD_W + 1;

    seq_state_t         st, st_n;
    uinsn_t             insn;
    logic               vec, at_limit, last_pt, point_end;
    logic               walk_init, walk_step, dma_load;
    logic [COORD_W-1:0] hl_q, vl_q, cur_x, cur_y;
    logic [31:0]        base_q;
    logic [2*SPAN_W-1:0] span_prod;
    logic               unused_fields;

    assign insn          = unpack_insn(ucode_data_i);
    assign vec           = is_vec_out(insn);
    assign unused_fields = ^{insn.spare, insn.dest};

    assign walk_init = (st == SEQ_IDLE) && start_i;
    assign dma_load  = (st == SEQ_RUN) && vec;
    assign issue_o   = (st == SEQ_RUN) && !vec;
    assign point_end = (issue_o && at_limit) || ((st == SEQ_DMA) && dma_req_o && dma_ack_i);
    assign walk_step = point_end && !last_pt;

    always_comb begin
        st_n = st;
        unique case (st)
            SEQ_IDLE: if (start_i) st_n = SEQ_LOAD;
            SEQ_LOAD: st_n = SEQ_RUN;
            SEQ_RUN: begin
                if (vec)            st_n = SEQ_DMA;
                else if (point_end) st_n = last_pt ? SEQ_DONE : SEQ_LOAD;
            end
            SEQ_DMA:  if (point_end) st_n = last_pt ? SEQ_DONE : SEQ_LOAD;
            SEQ_DONE: st_n = SEQ_IDLE;
            default:  st_n = SEQ_IDLE;
        endcase
    end

    assign span_prod = ({1'b0, hl_q} + 1'b1) * ({1'b0, vl_q} + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SEQ_IDLE;
            hl_q       <= '0;
            vl_q       <= '0;
            base_q     <= '0;
            vertices_o <= '0;
        end else begin
            st <= st_n;
            if (walk_init) begin
                hl_q   <= hlast_i;
                vl_q   <= vlast_i;
                base_q <= mesh_base_i;
            end
            if (st == SEQ_DONE) vertices_o <= 32'(span_prod);
        end
    end

    mesh_point_walker #(.COORD_W(COORD_W)) u_walk (
        .clk   (clk),
        .rst   (rst),
        .init  (walk_init),
        .step  (walk_step),
        .hlast (hl_q),
        .vlast (vl_q),
        .x     (cur_x),
        .y     (cur_y),
        .last  (last_pt)
    );

    mesh_insn_window #(.PC_W(PC_W), .INSN_LIMIT(INSN_LIMIT)) u_win (
        .clk      (clk),
        .rst      (rst),
        .clear    (st == SEQ_LOAD),
        .advance  (issue_o),
        .pc       (ucode_addr_o),
        .at_limit (at_limit)
    );

    mesh_dma_stage #(.COORD_W(COORD_W), .ROW_STRIDE(ROW_STRIDE)) u_dma (
        .clk       (clk),
        .rst       (rst),
        .load      (dma_load),
        .base      (base_q),
        .x         (cur_x),
        .y         (cur_y),
        .word_a    (rf_a_data_i),
        .word_b    (rf_b_data_i),
        .ack       (dma_ack_i),
        .req       (dma_req_o),
        .addr      (dma_addr_o),
        .word0     (dma_word0_o),
        .word1     (dma_word1_o),
        .last_addr (last_dma_o)
    );

    assign rf_a_idx_o = insn.src_a;
    assign rf_b_idx_o = insn.src_b;
    assign coord_we_o = (st == SEQ_LOAD);
    assign coord_x_o  = cur_x;
    assign coord_y_o  = cur_y;
    assign irq_o      = (st == SEQ_DONE);
    assign busy_o     = (st != SEQ_IDLE);
endmodule

// File: rtl/mesh_walk_seq_chk.sv
module mesh_walk_seq_chk #(
    parameter int PC_W = 11
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] ucode_addr_o,
    input logic            issue_o,
    input logic            coord_we_o,
    input logic            dma_req_o,
    input logic [31:0]     dma_addr_o,
    input logic [31:0]     dma_word0_o,
    input logic [31:0]     dma_word1_o,
    input logic            dma_ack_i,
    input logic            irq_o,
    input logic            busy_o
);
    assert_coord_pc0_R2: assert property (@(posedge clk) disable iff (rst)
        coord_we_o |=> (ucode_addr_o == '0));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        issue_o |=> (ucode_addr_o == PC_W'($past(ucode_addr_o) + 1'b1)));

    assert_dma_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o && !dma_ack_i) |=>
            (dma_req_o && $stable(dma_addr_o) && $stable(dma_word0_o) && $stable(dma_word1_o)));

    assert_no_issue_in_dma_R6: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> !issue_o);

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    assert_irq_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> busy_o ##1 !busy_o);
endmodule

bind mesh_walk_seq mesh_walk_seq_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/mesh_walk_seq_bench.sv
`timescale 1ns/1ps
module mesh_walk_seq_bench;
    localparam int CW  = 7;
    localparam int PW  = 11;
    localparam int LIM = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] hlast_i = '0, vlast_i = '0;
    logic [31:0]   mesh_base_i = 32'h0004_0000;
    logic [PW-1:0] ucode_addr_o;
    logic [31:0]   ucode_data_i;
    logic          issue_o;
    logic [6:0]    rf_a_idx_o, rf_b_idx_o;
    logic [31:0]   rf_a_data_i, rf_b_data_i;
    logic          coord_we_o;
    logic [CW-1:0] coord_x_o, coord_y_o;
    logic          dma_req_o;
    logic [31:0]   dma_addr_o, dma_word0_o, dma_word1_o;
    logic          dma_ack_i = 1'b0;
    logic [31:0]   last_dma_o, vertices_o;
    logic          irq_o, busy_o;

    always #2.5 clk = ~clk;

    mesh_walk_seq #(.COORD_W(CW), .ROW_STRIDE(128), .PC_W(PW), .INSN_LIMIT(LIM)) u_mesh_walk_seq (.*);

    int n_run = 0, n_fail = 0;

    // program model
    int         vec_pc = 2;
    logic [6:0] va = 7'd0, vb = 7'd1;
    bit         abort_en = 1'b0;
    logic [31:0] abort_xv = '0;
    logic [31:0] rx = '0, ry = '0;
    int         icnt = 0, dma_seen = 0;

    function automatic logic [31:0] mk(input logic [6:0] a, input logic [6:0] b, input logic [3:0] op);
        return {7'd0, a, b, op, 7'd2};
    endfunction

    function automatic logic [31:0] regval(input logic [6:0] idx, input logic [31:0] xv, input logic [31:0] yv);
        if (idx == 7'd0) return xv;
        if (idx == 7'd1) return yv;
        return 32'hC0DE_0000 | 32'(idx);
    endfunction

    always_comb begin
        if (abort_en && rx == abort_xv)          ucode_data_i = mk(7'd3, 7'd4, 4'd1);
        else if (int'(ucode_addr_o) == vec_pc)   ucode_data_i = mk(va, vb, 4'd7);
        else                                     ucode_data_i = mk(7'd3, 7'd4, 4'd1);
        rf_a_data_i = regval(rf_a_idx_o, rx, ry);
        rf_b_data_i = regval(rf_b_idx_o, rx, ry);
    end

    always @(posedge clk) begin
        if (coord_we_o) begin
            rx   <= 32'(coord_x_o);
            ry   <= 32'(coord_y_o);
            icnt <= 0;
        end else if (issue_o) begin
            icnt <= icnt + 1;
        end
        if (dma_req_o && dma_ack_i) dma_seen <= dma_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_sweep(input int h, input int v, input int hold, input bit mid_start);
        int exp_dma = 0;
        bit first = 1'b1;
        int d0 = dma_seen;
        logic [31:0] ea;
        @(negedge clk);
        hlast_i = CW'(h); vlast_i = CW'(v); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", 32'(busy_o), 1);
        for (int y = 0; y <= v; y++) begin
            for (int x = 0; x <= h; x++) begin
                while (!coord_we_o) @(negedge clk);
                chk(coord_x_o == CW'(x) && coord_y_o == CW'(y), "R1",
                    "point order {x,y}", {16'(coord_x_o), 16'(coord_y_o)}, {16'(x), 16'(y)});
                chk(coord_x_o == CW'(x), "R2", "coord x load", 32'(coord_x_o), 32'(x));
                if (mid_start && first) begin
                    start_i = 1'b1; hlast_i = CW'(h + 3); vlast_i = CW'(v + 2);
                    @(negedge clk);
                    start_i = 1'b0;
                end
                first = 1'b0;
                if (abort_en && 32'(x) == abort_xv) begin
                    do @(negedge clk); while (!(coord_we_o || irq_o));
                    chk(icnt == LIM, "R7", "issues before abort", 32'(icnt), LIM);
                    chk(dma_seen - d0 == exp_dma, "R7", "no write on abort", 32'(dma_seen - d0), 32'(exp_dma));
                end else begin
                    while (!dma_req_o) @(negedge clk);
                    ea = mesh_base_i + 32'(8 * (128 * y + x));
                    chk(icnt == vec_pc, "R3", "issues before output", 32'(icnt), 32'(vec_pc));
                    chk(dma_addr_o == ea, "R5", "write address", dma_addr_o, ea);
                    chk(dma_word0_o == regval(va, 32'(x), 32'(y)), "R4", "word0", dma_word0_o, regval(va, 32'(x), 32'(y)));
                    chk(dma_word1_o == regval(vb, 32'(x), 32'(y)), "R4", "word1", dma_word1_o, regval(vb, 32'(x), 32'(y)));
                    for (int k = 0; k < hold; k++) begin
                        @(negedge clk);
                        chk(dma_req_o && dma_addr_o == ea && dma_word0_o == regval(va, 32'(x), 32'(y)),
                            "R6", "held write", dma_addr_o, ea);
                        chk(icnt == vec_pc, "R6", "no issue while stalled", 32'(icnt), 32'(vec_pc));
                    end
                    dma_ack_i = 1'b1;
                    @(negedge clk);
                    dma_ack_i = 1'b0;
                    chk(last_dma_o == ea + 32'd4, "R5", "last write address", last_dma_o, ea + 32'd4);
                    exp_dma++;
                end
            end
        end
        while (!irq_o) @(negedge clk);
        chk(busy_o == 1'b1, "R9", "busy in irq cycle", 32'(busy_o), 1);
        @(negedge clk);
        chk(irq_o == 1'b0, "R8", "irq single cycle", 32'(irq_o), 0);
        chk(busy_o == 1'b0, "R9", "idle after irq", 32'(busy_o), 0);
        chk(vertices_o == 32'((h + 1) * (v + 1)), "R8", "vertex count", vertices_o, 32'((h + 1) * (v + 1)));
        chk(dma_seen - d0 == exp_dma, "R1", "write count", 32'(dma_seen - d0), 32'(exp_dma));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!busy_o && !irq_o && !dma_req_o && !coord_we_o && !issue_o, "R10", "idle outputs",
            {busy_o, irq_o, dma_req_o, coord_we_o, issue_o}, 0);
        chk(vertices_o == 0 && last_dma_o == 0, "R10", "cleared registers", vertices_o | last_dma_o, 0);
        rst = 1'b0;
    endtask

    task automatic t_basic();      // R1 R2 R3 R4 R5 R8
        vec_pc = 2; va = 7'd0; vb = 7'd1; abort_en = 1'b0;
        run_sweep(2, 1, 0, 1'b0);
    endtask

    task automatic t_stall();      // R6 with other source fields, output at pc 0
        vec_pc = 0; va = 7'd5; vb = 7'd9; abort_en = 1'b0;
        run_sweep(1, 0, 4, 1'b0);
    endtask

    task automatic t_abort();      // R7 middle point has no output
        vec_pc = 1; va = 7'd1; vb = 7'd0; abort_en = 1'b1; abort_xv = 32'd1;
        run_sweep(2, 0, 0, 1'b0);
        abort_en = 1'b0;
    endtask

    task automatic t_edge();       // R7 output at last allowed slot
        vec_pc = LIM - 1; va = 7'd0; vb = 7'd1; abort_en = 1'b0;
        run_sweep(0, 0, 1, 1'b0);
    endtask

    task automatic t_busy_start(); // R9 restart ignored while busy
        vec_pc = 2; va = 7'd0; vb = 7'd1; abort_en = 1'b0;
        run_sweep(1, 1, 0, 1'b1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stall();
        t_abort();
        t_edge();
        t_busy_start();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end
endmodule